// File: doc/BRIEF.md
# Volt-Second Balance Trim Integrator

This block keeps the two halves of a two-phase switching converter at equal volt-seconds. In every switching period it receives two measurements, one from each half cycle, together with a cycle strobe. It integrates their signed difference into an accumulator at one of four gains, which rise in steps of four. The integer part of that accumulator is a signed pulse-width correction in 5 ns steps. The PWM stage adds this correction to one half cycle and subtracts it from the other.

The accumulator carries six fractional bits. At the lowest gain, one count of measurement difference moves the correction by 1/64 of an LSB. At the highest gain, the same count moves it by one full LSB. This gives a 64:1 span between slow and fast convergence. The correction saturates at a symmetric limit, either ±16 LSB (±80 ns) or ±32 LSB (±160 ns). Gain and range may be changed at any time while the block runs, and the new setting applies without a reset.

Top module: `vsb_trim_integrator`

## Requirements
- R1: On a clock edge with `cycle_stb` high, the accumulator (in units of 1/64 LSB) changes by (`meas_a` − `meas_b`) × G, where `gain_sel` 0, 1, 2, 3 selects G = 1, 4, 16, 64. The change is visible on `corr_out` after that edge.
- R2: A positive difference (`meas_a` > `meas_b`) never lowers `corr_out`. A negative difference never raises it.
- R3: With `range_hi` low, `corr_out` stays within −16 to +16 (±80 ns at 5 ns per LSB).
- R4: With `range_hi` high, `corr_out` stays within −32 to +32 (±160 ns). The value ±32 itself is reachable.
- R5: On an edge with `cycle_stb` low, the accumulator holds its value, unless the clamp of R7 applies.
- R6: `corr_out` is the accumulator's integer part, rounded toward minus infinity. An accumulator of −1/64 therefore reads −1, and +63/64 reads 0.
- R7: If the range is lowered while the accumulator is outside ±16, the accumulator is clamped to the nearest new limit on the next edge, even when no strobe is present.
- R8: An overflowing update saturates at the active limit and never wraps to the opposite sign.
- R9: A synchronous `rst` clears the accumulator, so `corr_out` is 0 after the edge. Reset takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_stb | input | 1 | One-cycle pulse per switching period |
| meas_a | input | 12 | First half-cycle measurement, unsigned |
| meas_b | input | 12 | Second half-cycle measurement, unsigned |
| gain_sel | input | 2 | Integration gain code (1, 4, 16, 64) |
| range_hi | input | 1 | 0 selects ±16 LSB, 1 selects ±32 LSB |
| corr_out | output | 7 | Signed correction, 5 ns per LSB |

## Verification
The bench walks small differences at gain 1, where the fractional bits matter. A design that dropped those bits or truncated toward zero would show 0 where −1 is expected. The bench then drives full-scale differences at gain 64 in both range settings. A design that wrapped on overflow would flip the sign, and one that used the wrong limit would stop at 16 instead of 32. Two more cases target timing and priority. The range is lowered with no strobe present, which shows whether the clamp waits for the next strobe. Reset is asserted together with a strobe, which shows whether the strobe wins over reset.

// File: rtl/vsb_trim_integrator.sv
module vsb_trim_integrator #(
  parameter int MEAS_W = 12,
  parameter int FRAC_W = 6,
  parameter int OUT_W  = 7,
  parameter int LIM_LO = 16,
  parameter int LIM_HI = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cycle_stb,
  input  logic [MEAS_W-1:0]        meas_a,
  input  logic [MEAS_W-1:0]        meas_b,
  input  logic [1:0]               gain_sel,
  input  logic                     range_hi,
  output logic signed [OUT_W-1:0]  corr_out
);
  localparam int ACC_W  = OUT_W + FRAC_W;
  localparam int STEP_W = MEAS_W + 7;
  localparam int SUM_W  = ((STEP_W > ACC_W) ? STEP_W : ACC_W) + 1;
  localparam logic signed [SUM_W-1:0] LO_MAX = SUM_W'(LIM_LO * (2 ** FRAC_W));
  localparam logic signed [SUM_W-1:0] HI_MAX = SUM_W'(LIM_HI * (2 ** FRAC_W));
  localparam logic signed [OUT_W-1:0] OUT_LO = OUT_W'(LIM_LO);
  localparam logic signed [OUT_W-1:0] OUT_HI = OUT_W'(LIM_HI);

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [MEAS_W:0]   diff;
  logic signed [STEP_W-1:0] step;
  logic signed [SUM_W-1:0]  inc, sum, lim;

  assign diff = $signed({1'b0, meas_a}) - $signed({1'b0, meas_b});
  assign step = STEP_W'(diff) <<< {gain_sel, 1'b0};
  assign inc  = cycle_stb ? SUM_W'(step) : SUM_W'(0);
  assign sum  = SUM_W'(acc_q) + inc;
  assign lim  = range_hi ? HI_MAX : LO_MAX;

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (sum > lim)  acc_q <= ACC_W'(lim);
    else if (sum < -lim) acc_q <= ACC_W'(-lim);
    else                 acc_q <= ACC_W'(sum);
  end

  assign corr_out = acc_q[ACC_W-1:FRAC_W];

  p_clear_r9: assert property (@(posedge clk) rst |=> corr_out == '0);

  p_lo_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !range_hi |=> (corr_out <= OUT_LO && corr_out >= -OUT_LO));

  p_hi_bound_r4: assert property (@(posedge clk) disable iff (rst)
    range_hi |=> (corr_out <= OUT_HI && corr_out >= -OUT_HI));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cycle_stb && range_hi) |=> $stable(corr_out));

  p_up_r2: assert property (@(posedge clk) disable iff (rst)
    (cycle_stb && meas_a > meas_b && range_hi) |=> corr_out >= $past(corr_out));

  p_down_r2: assert property (@(posedge clk) disable iff (rst)
    (cycle_stb && meas_a < meas_b && range_hi) |=> corr_out <= $past(corr_out));
endmodule

// File: tb/vsb_trim_integrator_tb.sv
`timescale 1ns/1ps
module vsb_trim_integrator_tb_top;
  logic clk = 1'b0;
  logic rst, stb, rng;
  logic [11:0] a, b;
  logic [1:0] g;
  logic signed [6:0] corr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vsb_trim_integrator dut_i (
    .clk(clk), .rst(rst), .cycle_stb(stb), .meas_a(a), .meas_b(b),
    .gain_sel(g), .range_hi(rng), .corr_out(corr)
  );

  typedef struct packed {
    logic stb; logic [11:0] a; logic [11:0] b; logic [1:0] g; logic rng;
    logic signed [6:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'd100,  12'd36,   2'd0, 1'b0,  7'sd1,  4'd1},
    '{1'b1, 12'd36,   12'd100,  2'd0, 1'b0,  7'sd0,  4'd2},
    '{1'b1, 12'd10,   12'd11,   2'd0, 1'b0, -7'sd1,  4'd6},
    '{1'b1, 12'd11,   12'd10,   2'd0, 1'b0,  7'sd0,  4'd6},
    '{1'b1, 12'd20,   12'd10,   2'd1, 1'b0,  7'sd0,  4'd6},
    '{1'b1, 12'd20,   12'd10,   2'd1, 1'b0,  7'sd1,  4'd1},
    '{1'b1, 12'd10,   12'd12,   2'd2, 1'b0,  7'sd0,  4'd1},
    '{1'b1, 12'd13,   12'd10,   2'd3, 1'b0,  7'sd3,  4'd1},
    '{1'b0, 12'd4000, 12'd0,    2'd3, 1'b0,  7'sd3,  4'd5},
    '{1'b1, 12'd4000, 12'd0,    2'd3, 1'b0,  7'sd16, 4'd3},
    '{1'b1, 12'd0,    12'd4000, 2'd3, 1'b1, -7'sd32, 4'd8},
    '{1'b1, 12'd0,    12'd0,    2'd3, 1'b1, -7'sd32, 4'd4},
    '{1'b0, 12'd0,    12'd0,    2'd3, 1'b0, -7'sd16, 4'd7},
    '{1'b1, 12'd0,    12'd4095, 2'd3, 1'b0, -7'sd16, 4'd3},
    '{1'b1, 12'd5,    12'd4,    2'd3, 1'b0, -7'sd15, 4'd1}
  };

  task automatic check(input logic signed [6:0] exp, input string tag);
    checks++;
    if (corr !== exp) begin
      errors++;
      $display("FAIL %s: corr_out actual %0d expected %0d", tag, corr, exp);
    end
  endtask

  task automatic step(input logic s, input logic [11:0] va, input logic [11:0] vb,
                      input logic [1:0] vg, input logic vr);
    stb = s; a = va; b = vb; g = vg; rng = vr;
    @(negedge clk);
    stb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; stb = 1'b0; a = '0; b = '0; g = '0; rng = 1'b0;
    repeat (3) @(negedge clk);
    check(7'sd0, "R9 reset state");
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].stb, VECS[i].a, VECS[i].b, VECS[i].g, VECS[i].rng);
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    rst = 1'b1; step(1'b0, 12'd0, 12'd0, 2'd0, 1'b0); rst = 1'b0;
    check(7'sd0, "R9 reset mid-run");
    step(1'b1, 12'd32, 12'd0, 2'd3, 1'b1);
    check(7'sd32, "R4 exact upper limit");
    step(1'b1, 12'd1, 12'd0, 2'd3, 1'b1);
    check(7'sd32, "R8 saturate at +32");
    step(1'b0, 12'd0, 12'd0, 2'd3, 1'b1);
    check(7'sd32, "R5 hold without strobe");
    step(1'b0, 12'd0, 12'd0, 2'd3, 1'b0);
    check(7'sd16, "R7 clamp on range drop");
    rst = 1'b1; step(1'b1, 12'd4000, 12'd0, 2'd3, 1'b1); rst = 1'b0;
    check(7'sd0, "R9 reset over strobe");
    step(1'b1, 12'd63, 12'd0, 2'd0, 1'b1);
    check(7'sd0, "R6 63/64 reads 0");
    step(1'b1, 12'd1, 12'd0, 2'd0, 1'b1);
    check(7'sd1, "R1 gain 1 carry");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule